// File: doc/BRIEF.md
# Triangle Down-Spread Profile Generator

This block produces a signed frequency-offset control word that traces a symmetric triangle below a nominal synthesizer frequency. The word is meant to trim a fractional loop divider or any equivalent frequency control. Starting from zero offset, the word ramps linearly down to a peak deviation over one half-period. It then ramps linearly back to zero over the next half-period and repeats. By default the modulation rate is 30 kHz and the depth is 0.5 % of nominal.

The nominal frequency arrives as an unsigned code in the same units as the offset. The peak deviation is computed from that code and a depth parameter in parts per million. The depth is clamped so that it never exceeds 0.6 % of nominal. The half-period length is derived from the system clock rate and the modulation rate. The ramp uses a quotient step plus a remainder carry, so the word lands on exactly the computed peak at the turnaround.

With the enable low (the reset default), the offset is zero. A direction flag and a one-cycle turnaround pulse expose the timing of the period. The block produces the profile only; applying it to a loop is the consumer's business.

Top module: `ssc_tri_gen`

## Requirements
- R1: During reset and while the enable is low, `freq_ofs` is 0, `ramp_rise` is 0 and `turn_pulse` is 0; the nominal code has no effect.
- R2: The half-period is H = CLK_HZ / (2·MOD_HZ) clock cycles (1666 at defaults). The peak is P = floor(nom_code · depth_ppm / 1 000 000). On the edge that samples the enable high after it was low, the offset stays 0 (phase k = 0). On each later edge k advances, and while falling the offset equals −floor(P·k / H).
- R3: After exactly H steps the offset equals −P. It then retraces −floor(P·k / H) with k counting down to 0, which gives a full period of 2H cycles.
- R4: `ramp_rise` is 0 while the offset is falling (phase k in 0..H−1 after a rise) and 1 while rising, including the cycle at the peak.
- R5: `turn_pulse` is high for exactly one cycle at the peak (the cycle the offset equals −P) and for one cycle at each return to zero offset, and never otherwise.
- R6: The offset is never positive.
- R7: The effective depth is min(SPREAD_PPM, LIMIT_PPM), with LIMIT_PPM = 6000 (0.6 %); a configured depth of 8000 ppm produces peak floor(nom·6000/10⁶).
- R8: Dropping the enable mid-ramp returns the offset to 0 on the next edge. The next enable restarts the profile from phase 0 with a falling ramp.
- R9: The nominal code is captured at activation and at each return to zero offset. A change in between has no effect until that return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ssc_en | input | 1 | Spread modulation enable |
| nom_code | input | 24 | Nominal frequency code (unsigned) |
| freq_ofs | output | 25 | Signed frequency offset, zero or negative |
| ramp_rise | output | 1 | 0 = falling half, 1 = rising half |
| turn_pulse | output | 1 | One-cycle pulse at each turnaround |

## Verification
The bench aims at the turnaround cycle. An off-by-one half-period counter would put the pulse and the peak one cycle early or late. A truncating per-cycle step would miss −P, which the maximum nominal code (P = 83886, a step with both a whole and a fractional part) exposes. A zero nominal code checks that the pulses keep their timing with a flat offset. A design that reloaded the nominal code on every cycle would show the wrong peak after a mid-period change. A design that kept its phase on disable would resume mid-ramp instead of from zero. A second instance with an excessive depth setting shows whether the 0.6 % clamp is applied.

// File: rtl/ssc_tri_pkg.sv
package ssc_tri_pkg;

    localparam int NOM_W  = 24;
    localparam int OFF_W  = NOM_W + 1;
    localparam int X_W    = NOM_W + 1;
    localparam int PROD_W = NOM_W + 24;
    localparam int PPM_DEN = 1000000;

    typedef logic [NOM_W-1:0] mag_t;

    typedef enum logic {
        RAMP_FALL = 1'b0,
        RAMP_RISE = 1'b1
    } ramp_dir_e;

    // per-cycle slope: integer part and remainder over the half-period
    typedef struct packed {
        mag_t whole;
        mag_t frac;
    } slope_t;

    function automatic int eff_ppm(input int req, input int lim);
        return (req > lim) ? lim : req;
    endfunction

    function automatic mag_t peak_of(input mag_t nom, input int ppm);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(nom) * PROD_W'(ppm);
        prod = prod / PROD_W'(PPM_DEN);
        return prod[NOM_W-1:0];
    endfunction

endpackage

// File: rtl/ssc_depth_calc.sv
module ssc_depth_calc
    import ssc_tri_pkg::*;
#(
    parameter int HALF_CYC = 1666,
    parameter int DEPTH_PPM = 5000
) (
    input  mag_t   nom,
    output slope_t slope
);
    localparam mag_t HALF_M = mag_t'(HALF_CYC);

    mag_t peak;

    always_comb begin
        peak        = peak_of(nom, DEPTH_PPM);
        slope.whole = peak / HALF_M;
        slope.frac  = peak % HALF_M;
    end
endmodule

// File: rtl/ssc_phase_ctrl.sv
module ssc_phase_ctrl
    import ssc_tri_pkg::*;
#(
    parameter int HALF_CYC = 1666
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    output logic      clr,
    output logic      load,
    output logic      step_fwd,
    output logic      step_bwd,
    output ramp_dir_e dir,
    output logic      pulse
);
    localparam int KW = $clog2(HALF_CYC + 1);
    localparam logic [KW-1:0] K_LAST = KW'(HALF_CYC - 1);

    logic          active;
    logic [KW-1:0] k;

    always_comb begin
        clr      = !en;
        step_fwd = en && active && (dir == RAMP_FALL);
        step_bwd = en && active && (dir == RAMP_RISE);
        // capture a new depth on activation and when the ramp regains nominal
        load     = en && (!active || (step_bwd && k == KW'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active <= 1'b0;
            k      <= '0;
            dir    <= RAMP_FALL;
            pulse  <= 1'b0;
        end else if (!active) begin
            active <= 1'b1;
            pulse  <= 1'b0;
        end else if (dir == RAMP_FALL) begin
            k <= k + KW'(1);
            if (k == K_LAST) begin
                dir   <= RAMP_RISE;
                pulse <= 1'b1;
            end else begin
                pulse <= 1'b0;
            end
        end else begin
            k <= k - KW'(1);
            if (k == KW'(1)) begin
                dir   <= RAMP_FALL;
                pulse <= 1'b1;
            end else begin
                pulse <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ssc_dda_ramp.sv
module ssc_dda_ramp
    import ssc_tri_pkg::*;
#(
    parameter int HALF_CYC = 1666
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   load,
    input  logic   step_fwd,
    input  logic   step_bwd,
    input  slope_t slope_in,
    output mag_t   mag
);
    localparam logic [X_W-1:0] HALF_X = X_W'(HALF_CYC);

    slope_t         slope_r;
    mag_t           mag_r, rem_r;
    logic [X_W-1:0] sum_f;
    logic           carry, borrow;
    mag_t           rem_fwd, mag_fwd, rem_bwd, mag_bwd;

    always_comb begin
        sum_f   = {1'b0, rem_r} + {1'b0, slope_r.frac};
        carry   = (sum_f >= HALF_X);
        rem_fwd = carry ? mag_t'(sum_f - HALF_X) : sum_f[NOM_W-1:0];
        mag_fwd = mag_r + slope_r.whole + mag_t'(carry);

        borrow  = (rem_r < slope_r.frac);
        rem_bwd = borrow ? mag_t'({1'b0, rem_r} + HALF_X - {1'b0, slope_r.frac})
                         : rem_r - slope_r.frac;
        mag_bwd = mag_r - slope_r.whole - mag_t'(borrow);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slope_r <= '0;
            mag_r   <= '0;
            rem_r   <= '0;
        end else begin
            if (load) slope_r <= slope_in;
            if (step_fwd) begin
                mag_r <= mag_fwd;
                rem_r <= rem_fwd;
            end else if (step_bwd) begin
                mag_r <= mag_bwd;
                rem_r <= rem_bwd;
            end
        end
    end

    assign mag = mag_r;
endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
    import ssc_tri_pkg::*;
#(
    parameter int CLK_HZ     = 100000000,
    parameter int MOD_HZ     = 30000,
    parameter int SPREAD_PPM = 5000,
    parameter int LIMIT_PPM  = 6000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ssc_en,
    input  logic [NOM_W-1:0]        nom_code,
    output logic signed [OFF_W-1:0] freq_ofs,
    output logic                    ramp_rise,
    output logic                    turn_pulse
);
    localparam int HALF_CYC = CLK_HZ / (2 * MOD_HZ);
    localparam int DEPTH    = eff_ppm(SPREAD_PPM, LIMIT_PPM);

    slope_t    slope;
    logic      clr, load, step_fwd, step_bwd;
    ramp_dir_e dir;
    mag_t      mag;

    ssc_depth_calc #(.HALF_CYC(HALF_CYC), .DEPTH_PPM(DEPTH)) u_depth (
        .nom   (nom_code),
        .slope (slope)
    );

    ssc_phase_ctrl #(.HALF_CYC(HALF_CYC)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .en       (ssc_en),
        .clr      (clr),
        .load     (load),
        .step_fwd (step_fwd),
        .step_bwd (step_bwd),
        .dir      (dir),
        .pulse    (turn_pulse)
    );

    ssc_dda_ramp #(.HALF_CYC(HALF_CYC)) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .load     (load),
        .step_fwd (step_fwd),
        .step_bwd (step_bwd),
        .slope_in (slope),
        .mag      (mag)
    );

    assign freq_ofs  = -$signed({1'b0, mag});
    assign ramp_rise = (dir == RAMP_RISE);
endmodule

// File: rtl/ssc_tri_chk.sv
module ssc_tri_chk
    import ssc_tri_pkg::*;
#(
    parameter int LIMIT_PPM = 6000
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ssc_en,
    input logic signed [OFF_W-1:0] freq_ofs,
    input logic                    ramp_rise,
    input logic                    turn_pulse
);
    localparam longint MAX_MAG = ((longint'(1) << NOM_W) - 1) * LIMIT_PPM / PPM_DEN;

    p_no_upward_r6: assert property (@(posedge clk) disable iff (rst)
        $signed(freq_ofs) <= 0);

    p_depth_cap_r7: assert property (@(posedge clk) disable iff (rst)
        longint'($signed(freq_ofs)) >= -MAX_MAG);

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !ssc_en |=> (freq_ofs == '0) && !ramp_rise && !turn_pulse);

    p_pulse_flips_r5: assert property (@(posedge clk) disable iff (rst)
        turn_pulse |-> (ramp_rise != $past(ramp_rise)));

    p_dir_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ssc_en && $past(ssc_en) && !turn_pulse) |-> $stable(ramp_rise));

    p_fall_monotone_r2: assert property (@(posedge clk) disable iff (rst)
        (ssc_en && $past(ssc_en) && !ramp_rise && !turn_pulse)
            |-> $signed(freq_ofs) <= $signed($past(freq_ofs)));

    p_rise_monotone_r3: assert property (@(posedge clk) disable iff (rst)
        (ssc_en && $past(ssc_en) && ramp_rise && !turn_pulse)
            |-> $signed(freq_ofs) >= $signed($past(freq_ofs)));
endmodule

bind ssc_tri_gen ssc_tri_chk #(.LIMIT_PPM(LIMIT_PPM)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ssc_en     (ssc_en),
    .freq_ofs   (freq_ofs),
    .ramp_rise  (ramp_rise),
    .turn_pulse (turn_pulse)
);

// File: tb/ssc_tri_gen_tb.sv
module ssc_tri_gen_tb;
    import ssc_tri_pkg::*;

    localparam longint H = 100000000 / (2 * 30000);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    en = 1'b0;
    logic                    en_c = 1'b0;
    logic [NOM_W-1:0]        nom = '0;
    logic signed [OFF_W-1:0] ofs, ofs_c;
    logic                    rise, rise_c, pls, pls_c;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ssc_tri_gen u_dut (
        .clk(clk), .rst(rst), .ssc_en(en), .nom_code(nom),
        .freq_ofs(ofs), .ramp_rise(rise), .turn_pulse(pls)
    );

    ssc_tri_gen #(.SPREAD_PPM(8000)) u_dut_clamp (
        .clk(clk), .rst(rst), .ssc_en(en_c), .nom_code(nom),
        .freq_ofs(ofs_c), .ramp_rise(rise_c), .turn_pulse(pls_c)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic longint peak_ppm(input longint n, input longint ppm);
        return n * ppm / 1000000;
    endfunction

    function automatic longint phase_k(input longint t);
        longint m;
        m = t % (2 * H);
        return (m <= H) ? m : 2 * H - m;
    endfunction

    function automatic longint exp_ofs(input longint p, input longint t);
        return -(p * phase_k(t) / H);
    endfunction

    task automatic check_cycle(input longint p, input longint t);
        longint m;
        m = t % (2 * H);
        chk("R2/R3 offset", longint'(ofs), exp_ofs(p, t));
        chk("R4 direction", longint'(rise), (m >= H) ? 1 : 0);
        chk("R5 pulse", longint'(pls), (t > 0 && (m == H || m == 0)) ? 1 : 0);
        chk("R6 non-positive", ($signed(ofs) <= 0) ? 1 : 0, 1);
    endtask

    task automatic stop_dut();
        en = 1'b0;
        en_c = 1'b0;
        tick();
        tick();
    endtask

    task automatic t_reset();
        nom = 24'd200000;
        en  = 1'b0;
        repeat (4) tick();
        chk("R1 reset offset", longint'(ofs), 0);
        chk("R1 reset dir", longint'(rise), 0);
        chk("R1 reset pulse", longint'(pls), 0);
        rst = 1'b0;
        repeat (5) tick();
        chk("R1 disabled offset", longint'(ofs), 0);
        chk("R1 disabled pulse", longint'(pls), 0);
    endtask

    task automatic t_profile(input longint n);
        longint p;
        p   = peak_ppm(n, 5000);
        nom = NOM_W'(n);
        en  = 1'b1;
        tick();
        for (longint t = 0; t <= 2 * H + 10; t++) begin
            if (t > 0) tick();
            check_cycle(p, t);
            if (t == H) chk("R3 peak exact", longint'(ofs), -p);
            if (t == 2 * H) chk("R3 back to nominal", longint'(ofs), 0);
            if (t == H - 1) chk("R5 no early pulse", longint'(pls), 0);
        end
        stop_dut();
    endtask

    task automatic t_clamp();
        en_c = 1'b1;
        nom  = 24'd200000;
        tick();
        for (longint t = 0; t <= H; t++) begin
            if (t > 0) tick();
            chk("R7 clamped offset", longint'(ofs_c), exp_ofs(1200, t));
        end
        chk("R7 clamped peak", longint'(ofs_c), -1200);
        chk("R7 turn pulse", longint'(pls_c), 1);
        stop_dut();
    endtask

    task automatic t_disable();
        nom = 24'd200000;
        en  = 1'b1;
        tick();
        for (longint t = 1; t <= 500; t++) begin
            tick();
            check_cycle(1000, t);
        end
        en = 1'b0;
        tick();
        chk("R8 offset cleared", longint'(ofs), 0);
        chk("R8 dir cleared", longint'(rise), 0);
        chk("R8 no pulse", longint'(pls), 0);
        en = 1'b1;
        tick();
        for (longint t = 0; t <= 20; t++) begin
            if (t > 0) tick();
            check_cycle(1000, t);
        end
        stop_dut();
    endtask

    task automatic t_nom_latch();
        nom = 24'd200000;
        en  = 1'b1;
        tick();
        for (longint t = 1; t <= 3 * H; t++) begin
            tick();
            if (t == 100) nom = 24'd400000;
            if (t == H) chk("R9 old peak kept", longint'(ofs), -1000);
            if (t == 2 * H) chk("R9 return to zero", longint'(ofs), 0);
            if (t == 2 * H + 833) chk("R9 new slope", longint'(ofs), -1000);
            if (t == 3 * H) chk("R9 new peak", longint'(ofs), -2000);
        end
        stop_dut();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_profile(200000);
        t_profile(16777215);
        t_profile(0);
        t_clamp();
        t_disable();
        t_nom_latch();
        report();
    end
endmodule